// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Timer Bank

This block holds a small bank of PWM timer channels. Each channel has one down counter. Software never writes that counter directly. It writes a period buffer and a compare buffer, and the live counter and live compare register take those values only at two moments: when the counter wraps with auto-reload enabled, or while the channel's manual-update flag is set. A period therefore lasts the period-buffer value plus one ticks. For a period of P ticks and a duty of D ticks (D at least 1), software loads the compare buffer with P − D − 1. Each channel advances only on its own tick enable, which an external clock stage supplies.

All channels share one control word. Each channel owns a four-bit group in that word: a run flag, a manual-update flag, an output-invert flag and an auto-reload flag. Channel 0 uses the lowest group. The next group up is reserved. Every later channel sits one group higher than its index. On channel 4 the auto-reload flag takes the slot that the invert flag uses elsewhere, so that channel has no invert control.

Before inversion, a channel's duty phase is active while the live counter is above the live compare value. An all-ones compare value is always active. The pin shows the complement of the duty phase unless the invert flag is set, so software sets that flag to get normal polarity. Clearing auto-reload is how a channel is disabled: the current period runs to its end, the counter then stays at zero and the channel reports that it has stopped. The register write ports are plain single-cycle strobes and are always accepted. No data stream crosses the block's edge, so no port has back-pressure.

Top module: `pwmt_bank`

## Requirements
- R1: After reset, every live counter, compare value and buffer is zero and every run flag is clear. All pins are high, and all run and wrap outputs are low.
- R2: With run and auto-reload set and the tick always high, a channel whose period buffer holds N wraps every N+1 cycles. Each wrap gives a one-cycle pulse on its wrap output.
- R3: With the invert flag set and compare value C < N, the pin is high for N − C ticks of each period. It is never high when C ≥ N.
- R4: A compare value of all ones keeps the pin high for the whole period when the invert flag is set.
- R5: With the invert flag clear, the pin is low exactly where it would be high with the flag set.
- R6: A buffer write while the channel is running does not change the period in progress. The new value takes effect at the next wrap.
- R7: While the manual-update flag is set, both buffers are copied into the live registers every cycle and the channel neither counts nor wraps. Counting restarts from the copied period once the flag clears.
- R8: The live counter changes only on cycles with the channel's tick high or with manual update set. A wrap pulse only follows a cycle whose tick was high.
- R9: If auto-reload is cleared while a channel runs, exactly one more wrap occurs at the end of the current period. The counter then stays at zero, the run output goes low and no further wrap pulse occurs.
- R10: Control word layout: channel 0 uses bits 3:0 and channel k ≥ 1 uses bits 4(k+1)+3 : 4(k+1). Within a group, offset 0 is run, offset 1 is manual update, offset 2 is invert and offset 3 is auto-reload. Bits 7:4 are reserved.
- R11: On channel 4, auto-reload is at offset 2 (bit 22). Bit 23 has no effect, and that channel's pin is always the complement of its duty phase.
- R12: While a channel's run output is low, its wrap output is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | NUM_CH | Per-channel count enable from the clock stage |
| ctl_we_i | input | 1 | Write strobe for the shared control word |
| ctl_wdata_i | input | 4*(NUM_CH+1) | New control word |
| buf_sel_i | input | $clog2(NUM_CH) | Channel whose buffer is written |
| cnt_we_i | input | 1 | Write strobe for the period buffer |
| cmp_we_i | input | 1 | Write strobe for the compare buffer |
| buf_wdata_i | input | CNT_W | Buffer write data |
| pwm_o | output | NUM_CH | PWM pins |
| uf_o | output | NUM_CH | One-cycle wrap pulses |
| run_o | output | NUM_CH | Channel counting (run set and not stopped) |

## Verification
The assertions check four properties on every cycle and for every channel: the counter steps down by exactly one per enabled tick, the counter holds when there is neither a tick nor a manual update, a wrap never appears without a preceding tick, and a stopped channel never wraps. Some behaviour is only visible over whole periods or across a sequence of register writes, and only the bench scenarios can show it. This covers the duty counts for several period and compare pairs, the all-ones and inverted cases, the deferral of buffer writes to the next wrap, the single final wrap after auto-reload is cleared, and the odd bit placement of channel 4.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef struct packed {
    logic start;
    logic load;
    logic inv;
    logic arl;
  } pwmt_ctl_t;

  // Channel whose auto-reload flag is displaced and which lacks an invert flag
  localparam int unsigned PWMT_SHORT_CH = 4;

  function automatic int unsigned pwmt_nibble(input int unsigned ch);
    return (ch == 0) ? 0 : ch + 1;
  endfunction

  function automatic int unsigned pwmt_arl_pos(input int unsigned ch);
    return (ch == PWMT_SHORT_CH) ? 2 : 3;
  endfunction

endpackage

// File: rtl/pwmt_ctl_decode.sv
module pwmt_ctl_decode
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  localparam int unsigned CTL_W = 4 * (NUM_CH + 1)
) (
  input  logic [CTL_W-1:0]             ctl_word_i,
  output pwmt_ctl_t [NUM_CH-1:0]       ctl_o
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    localparam int unsigned BASE = 4 * pwmt_nibble(c);
    localparam int unsigned ARLB = BASE + pwmt_arl_pos(c);
    assign ctl_o[c].start = ctl_word_i[BASE];
    assign ctl_o[c].load  = ctl_word_i[BASE+1];
    assign ctl_o[c].arl   = ctl_word_i[ARLB];
    if (c == PWMT_SHORT_CH) begin : g_noinv
      assign ctl_o[c].inv = 1'b0;
    end else begin : g_inv
      assign ctl_o[c].inv = ctl_word_i[BASE+2];
    end
  end

  // Reserved bits are collected here so they are visibly discarded
  logic [CTL_W-1:0] used_m;
  logic [CTL_W-1:0] unused_rsv;
  always_comb begin
    used_m = '0;
    for (int unsigned c = 0; c < NUM_CH; c++) begin
      used_m[4*pwmt_nibble(c) +: 3] = 3'b111;
      if (c != PWMT_SHORT_CH) used_m[4*pwmt_nibble(c)+3] = 1'b1;
    end
    unused_rsv = ctl_word_i & ~used_m;
  end

endmodule

// File: rtl/pwmt_outstage.sv
module pwmt_outstage #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             inv_i,
  output logic             pin_o
);

  logic duty_act;

  always_comb begin
    duty_act = (cmp_i == {CNT_W{1'b1}}) || (cnt_i > cmp_i);
    pin_o    = inv_i ? duty_act : ~duty_act;
  end

endmodule

// File: rtl/pwmt_channel.sv
module pwmt_channel
  import pwmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  pwmt_ctl_t        ctl_i,
  input  logic             cnt_we_i,
  input  logic             cmp_we_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic             pwm_o,
  output logic             uf_o,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_buf, cmp_buf;
  logic [CNT_W-1:0] cnt_q, cmp_q;
  logic             stop_q;
  logic             uf_q;
  logic             at_zero;
  logic             running;

  assign at_zero = (cnt_q == '0);
  assign running = ctl_i.start & ~stop_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_buf <= '0;
      cmp_buf <= '0;
      cnt_q   <= '0;
      cmp_q   <= '0;
      stop_q  <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      if (cnt_we_i) cnt_buf <= wdata_i;
      if (cmp_we_i) cmp_buf <= wdata_i;
      uf_q <= 1'b0;
      if (!ctl_i.start) stop_q <= 1'b0;
      if (ctl_i.load) begin
        cnt_q  <= cnt_buf;
        cmp_q  <= cmp_buf;
        stop_q <= 1'b0;
      end else if (running && tick_i) begin
        if (at_zero) begin
          uf_q <= 1'b1;
          if (ctl_i.arl) begin
            cnt_q <= cnt_buf;
            cmp_q <= cmp_buf;
          end else begin
            stop_q <= 1'b1;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  pwmt_outstage #(.CNT_W(CNT_W)) u_out (
    .cnt_i (cnt_q),
    .cmp_i (cmp_q),
    .inv_i (ctl_i.inv),
    .pin_o (pwm_o)
  );

  assign uf_o  = uf_q;
  assign run_o = running;
  assign cnt_o = cnt_q;

endmodule

// File: rtl/pwmt_bank.sv
module pwmt_bank
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16,
  localparam int unsigned CTL_W = 4 * (NUM_CH + 1),
  localparam int unsigned SEL_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] tick_i,
  input  logic              ctl_we_i,
  input  logic [CTL_W-1:0]  ctl_wdata_i,
  input  logic [SEL_W-1:0]  buf_sel_i,
  input  logic              cnt_we_i,
  input  logic              cmp_we_i,
  input  logic [CNT_W-1:0]  buf_wdata_i,
  output logic [NUM_CH-1:0] pwm_o,
  output logic [NUM_CH-1:0] uf_o,
  output logic [NUM_CH-1:0] run_o
);

  logic [CTL_W-1:0]                ctl_q;
  pwmt_ctl_t [NUM_CH-1:0]          ctl_w;
  logic [NUM_CH-1:0][CNT_W-1:0]    cnt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else if (ctl_we_i) ctl_q <= ctl_wdata_i;
  end

  pwmt_ctl_decode #(.NUM_CH(NUM_CH)) u_dec (
    .ctl_word_i (ctl_q),
    .ctl_o      (ctl_w)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic hit;
    assign hit = (buf_sel_i == SEL_W'(c));
    pwmt_channel #(.CNT_W(CNT_W)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_i[c]),
      .ctl_i    (ctl_w[c]),
      .cnt_we_i (cnt_we_i & hit),
      .cmp_we_i (cmp_we_i & hit),
      .wdata_i  (buf_wdata_i),
      .pwm_o    (pwm_o[c]),
      .uf_o     (uf_o[c]),
      .run_o    (run_o[c]),
      .cnt_o    (cnt_w[c])
    );
  end

endmodule

// File: rtl/pwmt_bank_chk.sv
module pwmt_bank_chk
  import pwmt_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NUM_CH-1:0]             tick_i,
  input logic [NUM_CH-1:0]             uf_o,
  input logic [NUM_CH-1:0]             run_o,
  input pwmt_ctl_t [NUM_CH-1:0]        ctl_w,
  input logic [NUM_CH-1:0][CNT_W-1:0]  cnt_w
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_o[c] && tick_i[c] && !ctl_w[c].load && cnt_w[c] != '0)
      |=> (cnt_w[c] == $past(cnt_w[c]) - 1'b1));
    // R8
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i[c] && !ctl_w[c].load) |=> $stable(cnt_w[c]));
    // R8
    wrap_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      uf_o[c] |-> $past(tick_i[c]));
    // R12
    idle_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_o[c] |=> !uf_o[c]);
  end

endmodule

bind pwmt_bank pwmt_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .tick_i (tick_i),
  .uf_o   (uf_o),
  .run_o  (run_o),
  .ctl_w  (ctl_w),
  .cnt_w  (cnt_w)
);

// File: tb/pwmt_bank_bench.sv
module pwmt_bank_bench;

  localparam int NUM_CH = 5;
  localparam int CNT_W  = 16;
  localparam int CTL_W  = 4 * (NUM_CH + 1);
  localparam int SEL_W  = $clog2(NUM_CH);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NUM_CH-1:0] tick_i = '1;
  logic              ctl_we_i = 1'b0;
  logic [CTL_W-1:0]  ctl_wdata_i = '0;
  logic [SEL_W-1:0]  buf_sel_i = '0;
  logic              cnt_we_i = 1'b0;
  logic              cmp_we_i = 1'b0;
  logic [CNT_W-1:0]  buf_wdata_i = '0;
  logic [NUM_CH-1:0] pwm_o, uf_o, run_o;

  int tests = 0;
  int fails = 0;
  logic [CTL_W-1:0] shadow = '0;

  always #4 clk = ~clk;

  pwmt_bank #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_pwmt_bank (
    .clk, .rst_n, .tick_i, .ctl_we_i, .ctl_wdata_i, .buf_sel_i,
    .cnt_we_i, .cmp_we_i, .buf_wdata_i, .pwm_o, .uf_o, .run_o
  );

  // Fields: [32:17] period buffer N, [16:1] compare C, [0] invert
  localparam logic [32:0] VEC [8] = '{
    {16'd9, 16'd4,      1'b1},
    {16'd9, 16'd0,      1'b1},
    {16'd9, 16'd8,      1'b1},
    {16'd7, 16'hFFFF,   1'b1},
    {16'd9, 16'd2,      1'b0},
    {16'd5, 16'd9,      1'b1},
    {16'd3, 16'd1,      1'b1},
    {16'd7, 16'hFFFF,   1'b0}
  };

  task automatic check(input string tag, input int got, input int exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic write_ctl();
    @(negedge clk);
    ctl_we_i = 1'b1; ctl_wdata_i = shadow;
    @(negedge clk);
    ctl_we_i = 1'b0;
  endtask

  // Bit positions from R10 and R11
  task automatic set_ch(input int ch, input bit st, input bit ld, input bit iv, input bit ar);
    int b;
    b = 4 * ((ch == 0) ? 0 : ch + 1);
    shadow[b+:4] = '0;
    shadow[b]   = st;
    shadow[b+1] = ld;
    if (ch == 4) shadow[b+2] = ar;
    else begin
      shadow[b+2] = iv;
      shadow[b+3] = ar;
    end
    write_ctl();
  endtask

  task automatic write_buf(input int ch, input bit is_cmp, input logic [CNT_W-1:0] v);
    @(negedge clk);
    buf_sel_i = SEL_W'(ch); buf_wdata_i = v;
    if (is_cmp) cmp_we_i = 1'b1; else cnt_we_i = 1'b1;
    @(negedge clk);
    cnt_we_i = 1'b0; cmp_we_i = 1'b0;
  endtask

  task automatic start_ch(input int ch, input int n, input logic [CNT_W-1:0] c, input bit iv);
    write_buf(ch, 1'b0, CNT_W'(n));
    write_buf(ch, 1'b1, c);
    set_ch(ch, 1'b0, 1'b1, iv, 1'b1);
    set_ch(ch, 1'b1, 1'b0, iv, 1'b1);
  endtask

  task automatic count_win(input int ch, input int n, output int highs, output int wraps);
    highs = 0; wraps = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      highs += int'(pwm_o[ch]);
      wraps += int'(uf_o[ch]);
    end
  endtask

  task automatic wait_uf(input int ch, output int gap);
    gap = 0;
    for (int k = 0; k < 100; k++) begin
      @(negedge clk);
      gap++;
      if (uf_o[ch]) return;
    end
    gap = -1;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int h, w, g, p, act, n, c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", int'(pwm_o), 31);
    check("R1 run", int'(run_o), 0);
    check("R1 wrap", int'(uf_o), 0);

    // Table: R2 R3 R4 R5 on channel 1
    for (int v = 0; v < 8; v++) begin
      n = int'(VEC[v][32:17]);
      c = int'(VEC[v][16:1]);
      p = n + 1;
      start_ch(1, n, VEC[v][16:1], VEC[v][0]);
      act = (c == 16'hFFFF) ? p : ((c < n) ? n - c : 0);
      if (!VEC[v][0]) act = p - act;
      count_win(1, 2 * p, h, w);
      check($sformatf("R3/R4/R5 vec%0d highs", v), h, 2 * act);
      check($sformatf("R2 vec%0d wraps", v), w, 2);
    end

    // R6: buffer writes mid-period are deferred
    start_ch(1, 9, 16'd4, 1'b1);
    wait_uf(1, g);
    write_buf(1, 1'b0, 16'd3);
    write_buf(1, 1'b1, 16'd1);
    wait_uf(1, g);
    check("R6 old period kept", g + 4, 10);
    wait_uf(1, g);
    check("R6 new period", g, 4);

    // R7: manual update holds and copies
    write_buf(1, 1'b0, 16'd9);
    set_ch(1, 1'b1, 1'b1, 1'b1, 1'b1);
    count_win(1, 6, h, w);
    check("R7 no wrap while loading", w, 0);
    check("R7 copied compare gives duty high", h, 6);
    set_ch(1, 1'b1, 1'b0, 1'b1, 1'b1);
    wait_uf(1, g);
    check("R7 restart period", g, 10);

    // R9: clearing auto-reload stops after the current period
    set_ch(1, 1'b1, 1'b0, 1'b1, 1'b0);
    count_win(1, 25, h, w);
    check("R9 final wraps", w, 1);
    check("R9 run low", int'(run_o[1]), 0);
    count_win(1, 20, h, w);
    check("R9 no wraps after stop", w, 0);
    check("R9 pin parked low", h, 0);

    // R8: no tick, no progress
    tick_i[1] = 1'b0;
    start_ch(1, 4, 16'd1, 1'b1);
    count_win(1, 20, h, w);
    check("R8 no wrap without tick", w, 0);
    check("R8 run high", int'(run_o[1]), 1);
    check("R8 pin static", h, 20);
    tick_i[1] = 1'b1;
    count_win(1, 10, h, w);
    check("R8 wraps with tick", w, 2);

    // R10: channels 0 and 3 by layout, channel 2 idle
    start_ch(0, 3, 16'd1, 1'b1);
    start_ch(3, 3, 16'd1, 1'b1);
    count_win(0, 8, h, w);
    check("R10 ch0 wraps", w, 2);
    count_win(3, 8, h, w);
    check("R10 ch3 wraps", w, 2);
    check("R10 ch3 highs", h, 4);
    count_win(2, 8, h, w);
    check("R10 ch2 idle", w, 0);

    // R11: channel 4 auto-reload at bit 22, no invert
    start_ch(4, 3, 16'd1, 1'b1);
    count_win(4, 12, h, w);
    check("R11 ch4 wraps", w, 3);
    check("R11 ch4 highs uninverted", h, 6);
    shadow[22] = 1'b0; shadow[23] = 1'b1;
    write_ctl();
    count_win(4, 12, h, w);
    check("R11 ch4 stops with bit23 only", int'(run_o[4]), 0);
    count_win(4, 8, h, w);
    check("R11 ch4 no further wraps", w, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule